// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers the interrupt flags of a small processor system into sixteen priority levels. It picks the highest level that is allowed to run and gives the CPU the address of the vector word to fetch for it. Each level owns a group of flag inputs, and each flag has its own enable bit. A level counts as pending when any of its enabled flags is set. The top level handles reset and cannot be masked. The next level down is gated only by its own enables. All lower levels also need the global interrupt enable, which is a register inside the block that the CPU writes.

The request, the level and the vector address are registered. Once a request is shown it stays frozen until the CPU acknowledges it. The acknowledge produces a one-cycle taken strobe, and arbitration then resumes. Two side functions run alongside. The block raises a reset request when an instruction fetch lands in the low peripheral-register region. It also raises a sleep request when the reset vector word reads back as erased, which stops the CPU from starting out of blank memory.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq_req`, `irq_taken`, `fetch_rst_req` and `sleep_req` are 0, `irq_vector` is FFFEh and `irq_level` is 15. Reset also clears the global enable to 0.
- R2: The vector shown for level n is FFE0h + 2·n.
- R3: Level 15 (flags 60..63) is pending when any of its flags is set. Its enable bits and the global enable are ignored.
- R4: Level 14 (flags 56..59) needs a flag set together with its own enable bit. The global enable has no effect on it.
- R5: Levels 0..13 are pending only when a flag and its enable bit are both set and the global enable is 1.
- R6: Flag bit 4·n+k (k = 0..3) belongs to level n. A level is pending when any flag of its group is set with the matching enable bit; a flag whose own enable is 0 does not count.
- R7: When several levels are pending, the highest-numbered one is presented. Lower levels that remain pending are presented after it is acknowledged.
- R8: A request appears on the outputs one clock after its level becomes pending. While `irq_req` is 1 and `irq_ack` is 0, the request, level and vector do not change, even if a higher level arrives.
- R9: `irq_ack` while `irq_req` is 1 drops `irq_req` and raises `irq_taken` for exactly one cycle on the next clock. Arbitration resumes on the clock after that.
- R10: A valid fetch from an address below 0200h raises `fetch_rst_req` for one cycle on the next clock. Address 01FFh triggers it; 0200h and invalid fetches do not.
- R11: A reset-vector read of FFFFh sets `sleep_req`, which stays set until reset or until a reset-vector read of any other value.
- R12: `gie_wr` loads `gie_wdata` into the global enable on the clock edge. The new value gates arbitration from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | 64 | Pending flags, four per level |
| src_en | input | 64 | Per-flag enable bits |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| fetch_valid | input | 1 | An instruction fetch is under way |
| fetch_addr | input | 16 | Fetch address |
| rstvec_valid | input | 1 | The reset vector word is being read |
| rstvec_word | input | 16 | Value of the reset vector word |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 4 | Level of the presented request |
| irq_vector | output | 16 | Vector word address for the CPU to fetch |
| irq_taken | output | 1 | One-cycle strobe after an acknowledge |
| fetch_rst_req | output | 1 | Reset request for a fetch in the register region |
| sleep_req | output | 1 | Request for the deepest low-power mode |

## Verification
Directed patterns each place a flag in a single enable class and switch its individual and global enables, which separates the three gating rules from each other. Two-level and three-level pile-ups, with a higher level arriving while a lower one is held, separate plain priority from the hold-until-acknowledge rule. They also show whether the losing levels survive. The fetch guard is tried at both sides of the 0200h boundary. Random sparse flag and enable words, with random acknowledges, global-enable writes and fetches, are then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    CLS_RESET    = 2'd0,
    CLS_NOGLOBAL = 2'd1,
    CLS_MASKABLE = 2'd2
  } lvl_class_e;

  // Top level is the reset level, the one below ignores the global enable.
  function automatic lvl_class_e lvl_class(input int lvl, input int nlevels);
    if (lvl == nlevels - 1)      return CLS_RESET;
    else if (lvl == nlevels - 2) return CLS_NOGLOBAL;
    else                         return CLS_MASKABLE;
  endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_pkg::*;
#(
  parameter int NUM_LEVELS    = 16,
  parameter int SRC_PER_LEVEL = 4,
  localparam int NUM_SRC      = NUM_LEVELS * SRC_PER_LEVEL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    src_flag,
  input  logic [NUM_SRC-1:0]    src_en,
  input  logic                  gie,
  output logic [NUM_LEVELS-1:0] lvl_pend
);

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    localparam lvl_class_e CLS = lvl_class(l, NUM_LEVELS);
    logic [SRC_PER_LEVEL-1:0] grp_flag;
    logic [SRC_PER_LEVEL-1:0] grp_en;
    assign grp_flag = src_flag[l*SRC_PER_LEVEL +: SRC_PER_LEVEL];
    assign grp_en   = src_en[l*SRC_PER_LEVEL +: SRC_PER_LEVEL];

    if (CLS == CLS_RESET) begin : g_reset
      logic unused_grp_en;
      assign unused_grp_en = ^grp_en;
      assign lvl_pend[l] = |grp_flag;
      // R3: reset level cannot be masked
      p_reset_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
        (|grp_flag) |-> lvl_pend[l]);
    end else if (CLS == CLS_NOGLOBAL) begin : g_noglobal
      assign lvl_pend[l] = |(grp_flag & grp_en);
      // R4: global enable has no say here
      p_noglobal_r4: assert property (@(posedge clk) disable iff (rst)
        (!gie && (|(grp_flag & grp_en))) |-> lvl_pend[l]);
    end else begin : g_maskable
      assign lvl_pend[l] = gie & (|(grp_flag & grp_en));
      // R5: a maskable level never pends with the global enable off
      p_masked_r5: assert property (@(posedge clk) disable iff (rst)
        lvl_pend[l] |-> gie);
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LEVELS = 16,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] lvl_pend,
  output logic                  win_valid,
  output logic [LVL_W-1:0]      win_lvl
);

  // Scan upward so the last hit, the highest level, wins.
  always_comb begin
    win_valid = 1'b0;
    win_lvl   = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (lvl_pend[i]) begin
        win_valid = 1'b1;
        win_lvl   = LVL_W'(i);
      end
    end
  end

  // R7: the winner is pending and nothing above it is
  p_pick_highest_r7: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (lvl_pend[win_lvl] && ((lvl_pend >> win_lvl) == NUM_LEVELS'(1))));
  p_pick_none_r7: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (lvl_pend == '0));

endmodule

// File: rtl/irq_fetch_guard.sv
module irq_fetch_guard #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REG_LIMIT = 16'h0200,
  parameter logic [ADDR_W-1:0] ERASED    = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              rstvec_valid,
  input  logic [ADDR_W-1:0] rstvec_word,
  output logic              fetch_rst_req,
  output logic              sleep_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_rst_req <= 1'b0;
      sleep_req     <= 1'b0;
    end else begin
      fetch_rst_req <= fetch_valid && (fetch_addr < REG_LIMIT);
      if (rstvec_valid) sleep_req <= (rstvec_word == ERASED);
    end
  end

  // R10: illegal fetch gives a reset request on the next clock
  p_fetch_rst_r10: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && (fetch_addr < REG_LIMIT)) |=> fetch_rst_req);
  p_fetch_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !fetch_rst_req);
  // R11: erased reset vector sets the sleep request, which then sticks
  p_sleep_set_r11: assert property (@(posedge clk) disable iff (rst)
    (rstvec_valid && (rstvec_word == ERASED)) |=> sleep_req);
  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !rstvec_valid) |=> sleep_req);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int                NUM_LEVELS    = 16,
  parameter int                SRC_PER_LEVEL = 4,
  parameter int                ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE      = 16'hFFE0,
  parameter logic [ADDR_W-1:0] REG_LIMIT     = 16'h0200,
  parameter logic [ADDR_W-1:0] ERASED        = 16'hFFFF,
  localparam int               NUM_SRC       = NUM_LEVELS * SRC_PER_LEVEL,
  localparam int               LVL_W         = $clog2(NUM_LEVELS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_flag,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               gie_wr,
  input  logic               gie_wdata,
  input  logic               irq_ack,
  input  logic               fetch_valid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  input  logic               rstvec_valid,
  input  logic [ADDR_W-1:0]  rstvec_word,
  output logic               irq_req,
  output logic [LVL_W-1:0]   irq_level,
  output logic [ADDR_W-1:0]  irq_vector,
  output logic               irq_taken,
  output logic               fetch_rst_req,
  output logic               sleep_req
);

  localparam logic [LVL_W-1:0]  TOP_LVL = LVL_W'(NUM_LEVELS - 1);
  localparam logic [ADDR_W-1:0] RST_VEC = VEC_BASE + ADDR_W'((NUM_LEVELS - 1) * 2);

  logic                  gie_q;
  logic [NUM_LEVELS-1:0] lvl_pend;
  logic                  win_valid;
  logic [LVL_W-1:0]      win_lvl;
  logic [ADDR_W-1:0]     win_vec;

  irq_level_gate #(
    .NUM_LEVELS   (NUM_LEVELS),
    .SRC_PER_LEVEL(SRC_PER_LEVEL)
  ) u_gate (
    .clk     (clk),
    .rst     (rst),
    .src_flag(src_flag),
    .src_en  (src_en),
    .gie     (gie_q),
    .lvl_pend(lvl_pend)
  );

  irq_prio_pick #(
    .NUM_LEVELS(NUM_LEVELS)
  ) u_pick (
    .clk      (clk),
    .rst      (rst),
    .lvl_pend (lvl_pend),
    .win_valid(win_valid),
    .win_lvl  (win_lvl)
  );

  irq_fetch_guard #(
    .ADDR_W   (ADDR_W),
    .REG_LIMIT(REG_LIMIT),
    .ERASED   (ERASED)
  ) u_guard (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .rstvec_valid (rstvec_valid),
    .rstvec_word  (rstvec_word),
    .fetch_rst_req(fetch_rst_req),
    .sleep_req    (sleep_req)
  );

  assign win_vec = VEC_BASE + {{(ADDR_W-LVL_W-1){1'b0}}, win_lvl, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) gie_q <= 1'b0;
    else if (gie_wr) gie_q <= gie_wdata;
  end

  // Presentation register: frozen while a request waits for acknowledge.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req    <= 1'b0;
      irq_level  <= TOP_LVL;
      irq_vector <= RST_VEC;
      irq_taken  <= 1'b0;
    end else begin
      irq_taken <= irq_req && irq_ack;
      if (irq_req) begin
        if (irq_ack) irq_req <= 1'b0;
      end else if (win_valid) begin
        irq_req    <= 1'b1;
        irq_level  <= win_lvl;
        irq_vector <= win_vec;
      end
    end
  end

  // R2: vector and level agree while a request is shown
  p_vec_map_r2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vector == VEC_BASE + {{(ADDR_W-LVL_W-1){1'b0}}, irq_level, 1'b0}));
  // R8: held request is not re-arbitrated
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vector) && $stable(irq_level)));
  // R9: acknowledge yields a single taken pulse and drops the request
  p_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack) |=> (irq_taken && !irq_req));
  p_taken_once_r9: assert property (@(posedge clk) disable iff (rst)
    irq_taken |=> !irq_taken);
  // R12: global enable write takes effect for maskable level 0 on the next edge
  p_gie_off_r12: assert property (@(posedge clk) disable iff (rst)
    (gie_wr && !gie_wdata) |=> !lvl_pend[0]);

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

  localparam int NL = 16;
  localparam int SP = 4;
  localparam int NS = NL * SP;

  logic          clk = 1'b0;
  logic          rst;
  logic [NS-1:0] src_flag, src_en;
  logic          gie_wr, gie_wdata, irq_ack;
  logic          fetch_valid, rstvec_valid;
  logic [15:0]   fetch_addr, rstvec_word;
  logic          irq_req, irq_taken, fetch_rst_req, sleep_req;
  logic [3:0]    irq_level;
  logic [15:0]   irq_vector;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en),
    .gie_wr(gie_wr), .gie_wdata(gie_wdata), .irq_ack(irq_ack),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .rstvec_valid(rstvec_valid), .rstvec_word(rstvec_word),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
    .irq_taken(irq_taken), .fetch_rst_req(fetch_rst_req), .sleep_req(sleep_req)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // Bench model state
  bit        m_gie, m_req, m_taken, m_fetch, m_sleep;
  int        m_lvl;
  bit [15:0] m_vec;

  function automatic int best_level(bit [NS-1:0] f, bit [NS-1:0] e, bit g);
    int b = -1;
    for (int l = 0; l < NL; l++) begin
      bit any_f = 1'b0, any_fe = 1'b0;
      for (int k = 0; k < SP; k++) begin
        any_f  |= f[l*SP+k];
        any_fe |= f[l*SP+k] & e[l*SP+k];
      end
      if (l == 15 && any_f) b = l;              // R3
      else if (l == 14 && any_fe) b = l;        // R4
      else if (l < 14 && any_fe && g) b = l;    // R5, R6
    end
    return b;
  endfunction

  function automatic bit [15:0] vec_of(int l);
    return 16'hFFE0 + 16'(2 * l);               // R2
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: advance the model on the current inputs, compare after the edge.
  task automatic tick();
    int b;
    b = best_level(src_flag, src_en, m_gie);
    if (rst) begin
      m_gie = 0; m_req = 0; m_taken = 0; m_fetch = 0; m_sleep = 0;
      m_lvl = 15; m_vec = 16'hFFFE;
    end else begin
      m_taken = m_req && irq_ack;
      if (m_req) begin
        if (irq_ack) m_req = 0;
      end else if (b >= 0) begin
        m_req = 1; m_lvl = b; m_vec = vec_of(b);
      end
      if (gie_wr) m_gie = gie_wdata;
      m_fetch = fetch_valid && (fetch_addr < 16'h0200);
      if (rstvec_valid) m_sleep = (rstvec_word == 16'hFFFF);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R8 req model", 32'(irq_req), 32'(m_req));
    chk("R2 vector model", 32'(irq_vector), 32'(m_vec));
    chk("R7 level model", 32'(irq_level), 32'(m_lvl));
    chk("R9 taken model", 32'(irq_taken), 32'(m_taken));
    chk("R10 fetch model", 32'(fetch_rst_req), 32'(m_fetch));
    chk("R11 sleep model", 32'(sleep_req), 32'(m_sleep));
  endtask

  task automatic quiet();
    src_flag = '0; src_en = '0; gie_wr = 0; gie_wdata = 0; irq_ack = 0;
    fetch_valid = 0; fetch_addr = '0; rstvec_valid = 0; rstvec_word = '0;
  endtask

  task automatic ack_clear();
    irq_ack = 1; src_flag = '0; src_en = '0;
    tick();
    irq_ack = 0;
    tick();
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd20240611);
    quiet();
    rst = 1;
    repeat (3) tick();
    // R1: reset state
    chk("R1 req", 32'(irq_req), 0);
    chk("R1 vector", 32'(irq_vector), 32'hFFFE);
    chk("R1 level", 32'(irq_level), 15);
    chk("R1 sleep", 32'(sleep_req), 0);
    rst = 0;
    tick();
    chk("R1 fetch after reset", 32'(fetch_rst_req), 0);

    // R3: reset level ignores all enables
    src_flag[63] = 1;
    tick();
    chk("R3 req", 32'(irq_req), 1);
    chk("R3 vector", 32'(irq_vector), 32'hFFFE);
    // R9: acknowledge pulse
    irq_ack = 1; src_flag = '0;
    tick();
    chk("R9 taken", 32'(irq_taken), 1);
    chk("R9 req drop", 32'(irq_req), 0);
    irq_ack = 0;
    tick();
    chk("R9 taken single", 32'(irq_taken), 0);

    // R4: level 14 needs its enable, not the global enable
    src_flag[56] = 1;
    tick();
    chk("R4 no enable", 32'(irq_req), 0);
    src_en[56] = 1;
    tick();
    chk("R4 vector", 32'(irq_vector), 32'hFFFC);
    ack_clear();

    // R5 / R12 / R1: maskable level with global enable cleared by reset
    src_flag[12] = 1; src_en[12] = 1;
    tick();
    chk("R5 gie off", 32'(irq_req), 0);
    gie_wr = 1; gie_wdata = 1;
    tick();
    gie_wr = 0;
    chk("R12 write edge", 32'(irq_req), 0);
    tick();
    chk("R12 gie on vector", 32'(irq_vector), 32'hFFE6);
    ack_clear();

    // R6: enable on another flag of the same level does not count
    src_flag[20] = 1; src_en[21] = 1;
    tick();
    chk("R6 mismatched enable", 32'(irq_req), 0);
    src_flag[23] = 1; src_en[23] = 1;
    tick();
    chk("R6 shared level vector", 32'(irq_vector), 32'hFFEA);
    ack_clear();

    // R7 / R8: priority and hold
    src_flag[36] = 1; src_en[36] = 1; src_flag[8] = 1; src_en[8] = 1;
    tick();
    chk("R7 highest", 32'(irq_vector), 32'hFFF2);
    src_flag[60] = 1;
    tick();
    chk("R8 held despite higher", 32'(irq_vector), 32'hFFF2);
    irq_ack = 1; src_flag[36] = 0;
    tick();
    irq_ack = 0;
    tick();
    chk("R7 reset level next", 32'(irq_vector), 32'hFFFE);
    irq_ack = 1; src_flag[60] = 0;
    tick();
    irq_ack = 0;
    tick();
    chk("R7 lower kept pending", 32'(irq_vector), 32'hFFE4);
    ack_clear();

    // R10: fetch boundary
    fetch_valid = 1; fetch_addr = 16'h01FF;
    tick();
    chk("R10 01FF", 32'(fetch_rst_req), 1);
    fetch_addr = 16'h0200;
    tick();
    chk("R10 0200", 32'(fetch_rst_req), 0);
    fetch_valid = 0; fetch_addr = 16'h0000;
    tick();
    chk("R10 invalid", 32'(fetch_rst_req), 0);

    // R11: erased reset vector
    rstvec_valid = 1; rstvec_word = 16'hFFFF;
    tick();
    rstvec_valid = 0;
    tick();
    chk("R11 sticky", 32'(sleep_req), 1);
    rstvec_valid = 1; rstvec_word = 16'h4400;
    tick();
    chk("R11 cleared", 32'(sleep_req), 0);
    rstvec_word = 16'hFFFF;
    tick();
    rstvec_valid = 0;
    rst = 1;
    tick();
    chk("R1 sleep reset", 32'(sleep_req), 0);
    rst = 0;
    tick();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      src_flag = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      src_en   = {$urandom, $urandom};
      irq_ack  = ($urandom % 3) == 0;
      gie_wr   = ($urandom % 8) == 0;
      gie_wdata = $urandom % 2;
      fetch_valid = $urandom % 2;
      fetch_addr  = ($urandom % 2) ? 16'($urandom % 32'h400) : 16'($urandom);
      rstvec_valid = ($urandom % 16) == 0;
      rstvec_word  = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
      rst = ($urandom % 500) == 0;
      tick();
    end
    rst = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule